// File: doc/BRIEF.md
# Word FIFO Mailbox with Watermark Interrupts

The block carries 32-bit words one way, from a producer to a consumer. Both sides share one simple register port. The producer writes words into a push register. The consumer takes them out, oldest first, by reading a pop register. A level register reports the fill state of the queue. That state covers threshold reached, full, empty, and sticky flags for lost pushes and failed pops. The threshold itself is a programmable watermark. A flush register empties the queue without touching that threshold.

Interrupt causes are collected in one shared register, and software clears them by writing ones. The causes are:
- entry into full, empty or non-empty
- the watermark flag rising or falling
- a push while full
- a pop while empty

Two separate enable masks, one for the producer side and one for the consumer side, select which causes drive each side's interrupt line. Each side therefore reacts only to the events it cares about. A producer would typically wait for empty or overflow. A consumer would typically wait for the watermark to be crossed upward.

Top module: `mbx_fifo_mailbox`

## Requirements
- R1: After reset, the status register (0xB4) reads 0x4 (empty only) and the watermark register (0xB8) reads 32. The interrupt status (0xC8) reads 0, and both interrupt lines are low.
- R2: A register write to 0xAC appends its data word when the queue is not full. A register read of 0xB0 returns the oldest word and removes it. Words come out in write order.
- R3: A write to 0xAC while 32 words are held discards the data and leaves the contents unchanged. It sets status bit 4 (overflow, sticky) and interrupt bit 6.
- R4: A read of 0xB0 while empty returns 0 and leaves the occupancy at 0. It sets status bit 3 (underflow, sticky) and interrupt bit 7.
- R5: The status register holds the following flags, all derived from the state before the read:
  - bit 0: occupancy is at least the watermark
  - bit 1: occupancy equals 32
  - bit 2: occupancy is 0
- R6: A write to 0xB8 loads its low 6 bits as the watermark. Interrupt bit 4 is set on the clock edge where the watermark flag goes from 0 to 1, whether a push, pop, flush or watermark write caused the change. Interrupt bit 5 is set on the edge where the flag goes from 1 to 0, under the same causes.
- R7: Interrupt bit 2 is set on entry into full, bit 3 on entry into empty, and bit 8 on entry into non-empty. Each bit stays set until software clears it.
- R8: Writing to 0xC4 clears every interrupt status bit written as 1 and leaves the others unchanged.
- R9: 0xBC holds the producer enable mask and 0xC0 the consumer enable mask. Only bits 2 to 8 are writable; all other bits read 0. irq_prod is high while any enabled bit of the interrupt status is set under the producer mask, and irq_cons likewise under the consumer mask.
- R10: Writing 1 in bit 0 of 0xCC empties the queue and clears both sticky status flags. It keeps the watermark unchanged. A write to 0xCC with bit 0 clear has no effect.
- R11: Read data appears on reg_rdata one cycle after the read strobe. Reads of 0xAC, 0xC4, 0xCC and of any unmapped address return 0. A cycle with both strobes high performs only the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_prod | output | 1 | Producer-side interrupt |
| irq_cons | output | 1 | Consumer-side interrupt |

## Verification
The queue is driven by several kinds of traffic:
- A directed fill to exactly 32 words, followed by one extra push, separates the discard-and-flag path from normal storage.
- A full drain, followed by a pop from the empty queue, checks ordering and separates the zero-return underflow path.
- Watermark writes made while the occupancy sits on either side of the threshold show that the rising and falling edge bits fire on threshold changes as well as on occupancy changes.
- Random traffic with push-heavy and pop-heavy phases mixes clears, enable-mask changes and flushes. This exposes interactions between the sticky bits, the two side masks and the flush path.

// File: rtl/mbx_pkg.sv
// Package: register map, interrupt bit positions and shared types for the
// word FIFO mailbox. Addresses and bit positions are decoded by software
// and must stay fixed.
package mbx_pkg;

    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] A_PUSH    = 8'hAC;
    localparam logic [ADDR_W-1:0] A_POP     = 8'hB0;
    localparam logic [ADDR_W-1:0] A_STAT    = 8'hB4;
    localparam logic [ADDR_W-1:0] A_WMARK   = 8'hB8;
    localparam logic [ADDR_W-1:0] A_EN_PROD = 8'hBC;
    localparam logic [ADDR_W-1:0] A_EN_CONS = 8'hC0;
    localparam logic [ADDR_W-1:0] A_ICLR    = 8'hC4;
    localparam logic [ADDR_W-1:0] A_ISTAT   = 8'hC8;
    localparam logic [ADDR_W-1:0] A_FLUSH   = 8'hCC;

    localparam int IRQ_W     = 9;
    localparam int IB_FULL   = 2;
    localparam int IB_EMPTY  = 3;
    localparam int IB_WM_UP  = 4;
    localparam int IB_WM_DN  = 5;
    localparam int IB_OVF    = 6;
    localparam int IB_UDF    = 7;
    localparam int IB_NEMPTY = 8;

    localparam logic [IRQ_W-1:0] IRQ_WRITABLE = 9'h1FC;

    localparam int N_SIDES = 2;
    localparam int SIDE_PROD = 0;
    localparam int SIDE_CONS = 1;

    // Level conditions derived from occupancy and watermark
    typedef struct packed {
        logic wm;
        logic full;
        logic empty;
    } lvl_t;

endpackage

// File: rtl/mbx_word_fifo.sv
// Module: mbx_word_fifo
// Circular word store with occupancy counter. Push while full and pop while
// empty are refused and reported as lost events. Flush returns pointers and
// count to zero. Exposes both the current and the next-cycle occupancy so
// that downstream edge logic can act on the same clock edge.
// Assumes: push and pop are single-cycle strobes; flush overrides both.
module mbx_word_fifo #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic              flush,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [CNT_W-1:0]  cnt_nxt,
    output logic              push_lost,
    output logic              pop_lost
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_P  = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wp_q, rp_q;
    logic              is_full, is_empty, push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_P) ? '0 : p + 1'b1;
    endfunction

    // Accept/refuse decisions for this cycle
    always_comb begin
        is_full   = (cnt_q == DEPTH_C);
        is_empty  = (cnt_q == '0);
        push_ok   = push & ~is_full & ~flush;
        pop_ok    = pop & ~is_empty & ~flush;
        push_lost = push & is_full & ~flush;
        pop_lost  = pop & is_empty & ~flush;
    end

    // Next occupancy
    always_comb begin
        if (flush)
            cnt_nxt = '0;
        else
            cnt_nxt = cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end

    // Pointer and counter state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_nxt;
            if (flush) begin
                wp_q <= '0;
                rp_q <= '0;
            end else begin
                if (push_ok) wp_q <= bump(wp_q);
                if (pop_ok)  rp_q <= bump(rp_q);
            end
        end
    end

    // Word storage, written only on accepted pushes
    always_ff @(posedge clk) begin
        if (push_ok) mem[wp_q] <= wdata;
    end

    assign head = mem[rp_q];

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= DEPTH_C);

    assert_full_push_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && is_full && !flush && !pop) |=> (cnt_q == DEPTH_C));

    assert_empty_pop_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && is_empty && !flush && !push) |=> (cnt_q == '0));

endmodule

// File: rtl/mbx_irq_unit.sv
// Module: mbx_irq_unit
// Derives level flags from occupancy and watermark, detects their edges by
// comparing current and next-cycle values, and accumulates causes into a
// write-one-to-clear status vector. Each side gets its own masked line.
// Assumes: cnt_nxt/wm_nxt are the values registered on the coming edge.
module mbx_irq_unit
    import mbx_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [CNT_W-1:0]               cnt_q,
    input  logic [CNT_W-1:0]               cnt_nxt,
    input  logic [CNT_W-1:0]               wm_q,
    input  logic [CNT_W-1:0]               wm_nxt,
    input  logic                           ovf_evt,
    input  logic                           udf_evt,
    input  logic [IRQ_W-1:0]               clr_mask,
    input  logic [N_SIDES-1:0][IRQ_W-1:0]  en,
    output lvl_t                           lv_cur,
    output logic [IRQ_W-1:0]               ist_q,
    output logic [N_SIDES-1:0]             irq
);

    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    lvl_t             lv_nxt;
    logic [IRQ_W-1:0] set_vec;

    // Level flags now and after the coming edge
    always_comb begin
        lv_cur.wm    = (cnt_q >= wm_q);
        lv_cur.full  = (cnt_q == DEPTH_C);
        lv_cur.empty = (cnt_q == '0);
        lv_nxt.wm    = (cnt_nxt >= wm_nxt);
        lv_nxt.full  = (cnt_nxt == DEPTH_C);
        lv_nxt.empty = (cnt_nxt == '0);
    end

    // Causes raised on this edge
    always_comb begin
        set_vec             = '0;
        set_vec[IB_FULL]    = ~lv_cur.full & lv_nxt.full;
        set_vec[IB_EMPTY]   = ~lv_cur.empty & lv_nxt.empty;
        set_vec[IB_NEMPTY]  = lv_cur.empty & ~lv_nxt.empty;
        set_vec[IB_WM_UP]   = ~lv_cur.wm & lv_nxt.wm;
        set_vec[IB_WM_DN]   = lv_cur.wm & ~lv_nxt.wm;
        set_vec[IB_OVF]     = ovf_evt;
        set_vec[IB_UDF]     = udf_evt;
    end

    // Sticky cause register; a new cause wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) ist_q <= '0;
        else        ist_q <= (ist_q & ~clr_mask) | set_vec;
    end

    // Per-side masked interrupt lines
    for (genvar s = 0; s < N_SIDES; s++) begin : g_side
        assign irq[s] = |(ist_q & en[s]);
    end

    assert_ovf_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> ist_q[IB_OVF]);

    assert_udf_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        udf_evt |=> ist_q[IB_UDF]);

    assert_wm_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!lv_cur.wm && lv_nxt.wm) |=> ist_q[IB_WM_UP]);

    assert_wm_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lv_cur.wm && !lv_nxt.wm) |=> ist_q[IB_WM_DN]);

    assert_full_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!lv_cur.full && lv_nxt.full) |=> ist_q[IB_FULL]);

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_mask & ~set_vec) != '0) |=> ((ist_q & $past(clr_mask & ~set_vec)) == '0));

endmodule

// File: rtl/mbx_fifo_mailbox.sv
// Module: mbx_fifo_mailbox (top)
// Register front end of the word FIFO mailbox: decodes the single register
// port, holds watermark, enable masks and sticky loss flags, and returns
// registered read data. Queue storage and interrupt logic live in submodules.
// Assumes: one access per cycle; a write strobe masks a read in the same cycle.
module mbx_fifo_mailbox
    import mbx_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_prod,
    output logic              irq_cons
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] WM_RESET = CNT_W'(DEPTH);

    logic                          rd_act;
    logic                          do_push, do_pop, do_flush, do_wm, do_clr;
    logic [N_SIDES-1:0]            do_en;
    logic [CNT_W-1:0]              wm_q, wm_nxt, cnt_q, cnt_nxt;
    logic [DATA_W-1:0]             head;
    logic                          push_lost, pop_lost;
    logic                          ovf_st, udf_st;
    logic [N_SIDES-1:0][IRQ_W-1:0] en_q;
    logic [IRQ_W-1:0]              clr_mask, ist_q;
    logic [N_SIDES-1:0]            irq;
    lvl_t                          lv_cur;
    logic [DATA_W-1:0]             rd_mux;

    // Access decode
    always_comb begin
        rd_act           = reg_rd & ~reg_wr;
        do_push          = reg_wr & (reg_addr == A_PUSH);
        do_pop           = rd_act & (reg_addr == A_POP);
        do_flush         = reg_wr & (reg_addr == A_FLUSH) & reg_wdata[0];
        do_wm            = reg_wr & (reg_addr == A_WMARK);
        do_clr           = reg_wr & (reg_addr == A_ICLR);
        do_en[SIDE_PROD] = reg_wr & (reg_addr == A_EN_PROD);
        do_en[SIDE_CONS] = reg_wr & (reg_addr == A_EN_CONS);
        clr_mask         = do_clr ? reg_wdata[IRQ_W-1:0] : '0;
        wm_nxt           = do_wm ? reg_wdata[CNT_W-1:0] : wm_q;
    end

    // Watermark threshold register
    always_ff @(posedge clk) begin
        if (!rst_n) wm_q <= WM_RESET;
        else        wm_q <= wm_nxt;
    end

    // Per-side enable masks, only cause bits writable
    for (genvar s = 0; s < N_SIDES; s++) begin : g_en
        always_ff @(posedge clk) begin
            if (!rst_n)        en_q[s] <= '0;
            else if (do_en[s]) en_q[s] <= reg_wdata[IRQ_W-1:0] & IRQ_WRITABLE;
        end
    end

    // Sticky loss flags for the status register, cleared by flush
    always_ff @(posedge clk) begin
        if (!rst_n || do_flush) begin
            ovf_st <= 1'b0;
            udf_st <= 1'b0;
        end else begin
            if (push_lost) ovf_st <= 1'b1;
            if (pop_lost)  udf_st <= 1'b1;
        end
    end

    mbx_word_fifo #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (do_push),
        .pop       (do_pop),
        .flush     (do_flush),
        .wdata     (reg_wdata),
        .head      (head),
        .cnt_q     (cnt_q),
        .cnt_nxt   (cnt_nxt),
        .push_lost (push_lost),
        .pop_lost  (pop_lost)
    );

    mbx_irq_unit #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_q    (cnt_q),
        .cnt_nxt  (cnt_nxt),
        .wm_q     (wm_q),
        .wm_nxt   (wm_nxt),
        .ovf_evt  (push_lost),
        .udf_evt  (pop_lost),
        .clr_mask (clr_mask),
        .en       (en_q),
        .lv_cur   (lv_cur),
        .ist_q    (ist_q),
        .irq      (irq)
    );

    assign irq_prod = irq[SIDE_PROD];
    assign irq_cons = irq[SIDE_CONS];

    // Read data selection from pre-access state
    always_comb begin
        rd_mux = '0;
        case (reg_addr)
            A_POP:     rd_mux = lv_cur.empty ? '0 : head;
            A_STAT:    rd_mux = {{(DATA_W-5){1'b0}}, ovf_st, udf_st,
                                 lv_cur.empty, lv_cur.full, lv_cur.wm};
            A_WMARK:   rd_mux = {{(DATA_W-CNT_W){1'b0}}, wm_q};
            A_EN_PROD: rd_mux = {{(DATA_W-IRQ_W){1'b0}}, en_q[SIDE_PROD]};
            A_EN_CONS: rd_mux = {{(DATA_W-IRQ_W){1'b0}}, en_q[SIDE_CONS]};
            A_ISTAT:   rd_mux = {{(DATA_W-IRQ_W){1'b0}}, ist_q};
            default:   rd_mux = '0;
        endcase
    end

    // Registered read port, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (rd_act) reg_rdata <= rd_mux;
    end

    assert_pop_empty_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (do_pop && lv_cur.empty) |=> (reg_rdata == '0));

    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        do_flush |=> (cnt_q == '0 && !ovf_st && !udf_st));

    assert_flush_keeps_wm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        do_flush |=> $stable(wm_q));

    assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_act |=> $stable(reg_rdata));

endmodule

// File: tb/mbx_fifo_mailbox_tb_top.sv
// Self-checking bench: directed corner cases then seeded random traffic,
// compared against a reference model kept in bench variables.
module mbx_fifo_mailbox_tb_top;

    localparam int DEPTH = 32;
    localparam logic [7:0] A_PUSH = 8'hAC, A_POP = 8'hB0, A_STAT = 8'hB4,
        A_WM = 8'hB8, A_ENP = 8'hBC, A_ENC = 8'hC0, A_ICLR = 8'hC4,
        A_IST = 8'hC8, A_FLUSH = 8'hCC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_prod, irq_cons;

    int n_vec = 0;
    int n_bad = 0;

    // Reference model state
    logic [31:0] mq[$];
    int          m_wm = DEPTH;
    logic [8:0]  m_ist = '0, m_enp = '0, m_enc = '0;
    logic        m_ovf = 1'b0, m_udf = 1'b0;

    always #4 clk = ~clk;

    mbx_fifo_mailbox dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_prod  (irq_prod),
        .irq_cons  (irq_cons)
    );

    // {wm, full, empty} for a given occupancy and threshold
    function automatic logic [2:0] flags_of(input int sz, input int wm);
        return {sz >= wm, sz == DEPTH, sz == 0};
    endfunction

    function automatic string tag_of(input bit is_wr, input logic [7:0] a);
        case (a)
            A_PUSH:  return is_wr ? "R2" : "R11";
            A_POP:   return "R2";
            A_STAT:  return "R5";
            A_WM:    return "R6";
            A_ENP, A_ENC: return "R9";
            A_ICLR:  return "R8";
            A_IST:   return "R7";
            A_FLUSH: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    // Apply one access to the model; returns the expected read data
    task automatic model_apply(input bit is_wr, input logic [7:0] a,
                               input logic [31:0] d, output logic [31:0] exp);
        logic [2:0] f0, f1;
        logic [8:0] set, clr;
        set = '0; clr = '0; exp = '0;
        f0 = flags_of(mq.size(), m_wm);
        if (is_wr) begin
            case (a)
                A_PUSH: if (mq.size() == DEPTH) begin set[6] = 1'b1; m_ovf = 1'b1; end
                        else mq.push_back(d);
                A_WM:   m_wm = int'(d[5:0]);
                A_ENP:  m_enp = d[8:0] & 9'h1FC;
                A_ENC:  m_enc = d[8:0] & 9'h1FC;
                A_ICLR: clr = d[8:0];
                A_FLUSH: if (d[0]) begin mq.delete(); m_ovf = 1'b0; m_udf = 1'b0; end
                default: ;
            endcase
        end else begin
            case (a)
                A_POP:  if (mq.size() == 0) begin set[7] = 1'b1; m_udf = 1'b1; end
                        else exp = mq.pop_front();
                A_STAT: exp = {27'b0, m_ovf, m_udf, f0[0], f0[1], f0[2]};
                A_WM:   exp = 32'(m_wm);
                A_ENP:  exp = {23'b0, m_enp};
                A_ENC:  exp = {23'b0, m_enc};
                A_IST:  exp = {23'b0, m_ist};
                default: exp = '0;
            endcase
        end
        f1 = flags_of(mq.size(), m_wm);
        set[2] = !f0[1] && f1[1];
        set[3] = !f0[0] && f1[0];
        set[8] = f0[0] && !f1[0];
        set[4] = !f0[2] && f1[2];
        set[5] = f0[2] && !f1[2];
        m_ist = (m_ist & ~clr) | set;
    endtask

    task automatic bus_op(input bit is_wr, input logic [7:0] a,
                          input logic [31:0] d, input string tag);
        logic [31:0] exp;
        model_apply(is_wr, a, d, exp);
        @(negedge clk);
        reg_wr = is_wr; reg_rd = !is_wr; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0;
        if (!is_wr) check(tag, reg_rdata, exp);
        // R9: interrupt lines follow status under each mask
        check("R9 irq", {30'b0, irq_prod, irq_cons},
              {30'b0, |(m_ist & m_enp), |(m_ist & m_enc)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0C3A));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", {30'b0, irq_prod, irq_cons}, 32'h0);
        bus_op(0, A_STAT, 0, "R1 status");
        bus_op(0, A_WM, 0, "R1 watermark");
        bus_op(0, A_IST, 0, "R1 istat");

        // R9 enable masks, bits 0-1 not writable
        bus_op(1, A_ENP, 32'hFFFF_FFFF, "R9");
        bus_op(0, A_ENP, 0, "R9 enp readback");
        bus_op(1, A_ENP, 32'h48, "R9");
        bus_op(1, A_ENC, 32'h190, "R9");
        bus_op(0, A_ENC, 0, "R9 enc readback");

        // R2 fill to full; R5/R7 flags
        for (int i = 0; i < DEPTH; i++) bus_op(1, A_PUSH, 32'hA000_0000 + i, "R2");
        bus_op(0, A_STAT, 0, "R5 full status");
        bus_op(0, A_IST, 0, "R7 fill causes");
        // R3 overflow discards
        bus_op(1, A_PUSH, 32'hDEAD_BEEF, "R3");
        bus_op(0, A_STAT, 0, "R3 status");
        bus_op(0, A_IST, 0, "R3 istat");
        // R8 partial then full clear
        bus_op(1, A_ICLR, 32'h040, "R8");
        bus_op(0, A_IST, 0, "R8 partial clear");
        bus_op(1, A_ICLR, 32'h1FF, "R8");
        bus_op(0, A_IST, 0, "R8 full clear");
        // R2 drain in order
        for (int i = 0; i < DEPTH; i++) bus_op(0, A_POP, 0, "R2 pop order");
        bus_op(0, A_IST, 0, "R7 drain causes");
        // R4 pop while empty
        bus_op(0, A_POP, 0, "R4 empty pop");
        bus_op(0, A_STAT, 0, "R4 status");
        bus_op(0, A_IST, 0, "R4 istat");
        // R6 watermark crossings by occupancy and by threshold write
        bus_op(1, A_ICLR, 32'h1FF, "R8");
        bus_op(1, A_WM, 32'h3, "R6");
        for (int i = 0; i < 3; i++) bus_op(1, A_PUSH, 32'hB0 + i, "R2");
        bus_op(0, A_IST, 0, "R6 rise by push");
        bus_op(1, A_WM, 32'hA, "R6");
        bus_op(0, A_IST, 0, "R6 fall by write");
        bus_op(1, A_WM, 32'h2, "R6");
        bus_op(0, A_IST, 0, "R6 rise by write");
        // R10 flush
        bus_op(1, A_FLUSH, 32'h0, "R10");
        bus_op(0, A_STAT, 0, "R10 no-op flush");
        bus_op(1, A_FLUSH, 32'h1, "R10");
        bus_op(0, A_STAT, 0, "R10 flushed status");
        bus_op(0, A_WM, 0, "R10 watermark kept");
        // R11 write-only and unmapped reads
        bus_op(0, A_PUSH, 0, "R11 push read");
        bus_op(0, A_FLUSH, 0, "R11 flush read");
        bus_op(0, 8'h10, 0, "R11 unmapped");

        // Random phase with alternating push/pop bias
        for (int n = 0; n < 3000; n++) begin
            int r, bias;
            logic [7:0] a;
            logic [31:0] d;
            bit w;
            bias = ((n / 250) % 2 == 0) ? 55 : 15;
            r = int'($urandom_range(0, 99));
            d = $urandom();
            if (r < bias) begin w = 1; a = A_PUSH; end
            else if (r < 70) begin w = 0; a = A_POP; end
            else if (r < 76) begin w = 0; a = A_STAT; end
            else if (r < 82) begin w = 0; a = A_IST; end
            else if (r < 86) begin w = 1; a = A_ICLR; end
            else if (r < 90) begin w = 1; a = A_WM; d = 32'($urandom_range(0, 34)); end
            else if (r < 93) begin w = 1; a = ($urandom_range(0, 1) == 0) ? A_ENP : A_ENC; end
            else if (r < 96) begin w = 0; a = A_WM; end
            else if (r < 98) begin w = 1; a = A_FLUSH; end
            else begin w = 0; a = 8'($urandom_range(0, 255)); end
            bus_op(w, a, d, tag_of(w, a));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule